// File: doc/BRIEF.md
# RTC Prescaler and Test-Output Driver

This block counts a 32.768 kHz enable strobe down to one pulse per second for the calendar counters. It also produces a 1 Hz square wave and a 512 Hz test waveform. An open-drain output pin is modelled as a drive-low enable. A two-bit control field chooses what the pin shows: the 512 Hz test tone, or a static level held in a control bit.

A pulse on the chain-reset input clears the divider phase. The seconds-write path sends this pulse, so the next rising edge of the 1 Hz square wave comes exactly half a second later. The next calendar tick comes one full second later. A stop input freezes the divider in place.

Top module: `rtc_prescale_tout`

## Requirements
- R1: After reset, the test-select bit is 0, the level bit is 1, the divider is 0, and `pin_pull_low_o` is 0 (pin released).
- R2: The divider advances by one only on a clock where `tick_en_i` is 1 and `stop_i` is 0.
- R3: A `chain_rst_i` pulse clears the divider to 0 on the next clock edge, and it takes priority over stop and enable.
- R4: `sq_1hz_o` goes high on the 16384th counted enable after a chain reset. It goes low again when the divider wraps.
- R5: `tick_1hz_o` is a one-cycle pulse on the clock after the 32768th counted enable since a chain reset, and it is 0 on the cycles around it.
- R6: While `stop_i` is 1, the divider and every output derived from it hold their values.
- R7: A clock with `ctrl_we_i` high loads bit 6 of `ctrl_wdata_i` into the test-select bit and bit 7 into the level bit. The other bits are ignored.
- R8: With test-select at 1, the pin is pulled low while divider bit 5 is 0 and released while it is 1. This gives 512 Hz at a 50% duty cycle, whatever the level bit holds.
- R9: With test-select at 0, the pin is pulled low exactly when the level bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_en_i | input | 1 | 32.768 kHz enable strobe |
| stop_i | input | 1 | Oscillator stop; freezes the divider |
| chain_rst_i | input | 1 | Divider phase reset from a seconds write |
| ctrl_we_i | input | 1 | Control byte write strobe |
| ctrl_wdata_i | input | 8 | Control byte; bit 7 level, bit 6 test-select |
| tick_1hz_o | output | 1 | One-cycle pulse per second to the calendar |
| sq_1hz_o | output | 1 | 1 Hz square wave, MSB of the divider |
| pin_pull_low_o | output | 1 | Open-drain drive: 1 pulls the pin low |

## Verification
The following rules are checked by assertions on every cycle:
- the divider clears after a chain reset;
- the divider holds while stopped or without an enable;
- the calendar tick fires only when the divider is at zero;
- control writes land in the correct bits.

Only the bench scenarios can show the absolute timing: the half-second square-wave edge and the full-second tick position, counted in enables from a chain reset. The same holds for the 32-enable toggle of the test tone and for the output mux ignoring the level bit in test mode.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned CTRL_LVL_BIT = 7;
  localparam int unsigned CTRL_TST_BIT = 6;
endpackage

// File: rtl/rtc_divider.sv
module rtc_divider #(
  parameter int unsigned DIV_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             stop_i,
  input  logic             clr_i,
  output logic [DIV_W-1:0] cnt_o,
  output logic             tick_o
);
  localparam logic [DIV_W-1:0] CNT_MAX = {DIV_W{1'b1}};

  logic [DIV_W-1:0] cnt_q;
  logic             tick_q;
  logic             adv;

  assign adv = en_i && !stop_i && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= adv && (cnt_q == CNT_MAX);
      if (clr_i)    cnt_q <= '0;
      else if (adv) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign tick_o = tick_q;

  a_r3_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
  a_r6_stop_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !clr_i) |=> $stable(cnt_q));
  a_r2_no_en_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(cnt_q));
  a_r5_tick_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_q |-> cnt_q == '0);
endmodule

// File: rtl/rtc_tout_drv.sv
module rtc_tout_drv
  import rtc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  input  logic       tone_i,
  output logic       pull_low_o
);
  logic tst_q, lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tst_q <= 1'b0;
      lvl_q <= 1'b1;
    end else if (we_i) begin
      tst_q <= wdata_i[CTRL_TST_BIT];
      lvl_q <= wdata_i[CTRL_LVL_BIT];
    end
  end

  // open drain: only ever asserts a pull-down
  assign pull_low_o = tst_q ? !tone_i : !lvl_q;

  a_r7_tst_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> tst_q == $past(wdata_i[CTRL_TST_BIT]));
  a_r7_lvl_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> lvl_q == $past(wdata_i[CTRL_LVL_BIT]));
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(tst_q) && $stable(lvl_q));
endmodule

// File: rtl/rtc_prescale_tout.sv
module rtc_prescale_tout #(
  parameter int unsigned DIV_W    = 15,
  parameter int unsigned TONE_BIT = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_en_i,
  input  logic       stop_i,
  input  logic       chain_rst_i,
  input  logic       ctrl_we_i,
  input  logic [7:0] ctrl_wdata_i,
  output logic       tick_1hz_o,
  output logic       sq_1hz_o,
  output logic       pin_pull_low_o
);
  localparam int unsigned SQ_BIT = DIV_W - 1;

  logic [DIV_W-1:0] cnt;

  rtc_divider #(.DIV_W(DIV_W)) i_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (tick_en_i),
    .stop_i (stop_i),
    .clr_i  (chain_rst_i),
    .cnt_o  (cnt),
    .tick_o (tick_1hz_o)
  );

  assign sq_1hz_o = cnt[SQ_BIT];

  rtc_tout_drv i_drv (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (ctrl_we_i),
    .wdata_i    (ctrl_wdata_i),
    .tone_i     (cnt[TONE_BIT]),
    .pull_low_o (pin_pull_low_o)
  );

  a_r5_tick_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_1hz_o |=> !tick_1hz_o);
endmodule

// File: tb/test_rtc_prescale_tout.sv
module test_rtc_prescale_tout;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, stop = 1'b0, crst = 1'b0, we = 1'b0;
  logic [7:0] wd = 8'h00;
  logic       tick, sq, pin;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  typedef struct { string req; int sig; logic exp; } item_t;
  item_t sb[$];

  always #2.5ns clk = ~clk;

  rtc_prescale_tout i_rtc_prescale_tout (
    .clk_i(clk), .rst_ni(rst_n), .tick_en_i(en), .stop_i(stop),
    .chain_rst_i(crst), .ctrl_we_i(we), .ctrl_wdata_i(wd),
    .tick_1hz_o(tick), .sq_1hz_o(sq), .pin_pull_low_o(pin));

  // driver side: queue expected values (sig 0 pin, 1 sq, 2 tick)
  task automatic expect_v(string req, int sig, logic exp);
    item_t it;
    it.req = req; it.sig = sig; it.exp = exp;
    sb.push_back(it);
  endtask

  // monitor side: pop and compare against sampled outputs
  task automatic monitor();
    while (sb.size() > 0) begin
      item_t it;
      logic act;
      it = sb.pop_front();
      act = (it.sig == 0) ? pin : (it.sig == 1) ? sq : tick;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s sig%0d actual=%b expected=%b at %0t",
                 it.req, it.sig, act, it.exp, $time);
      end
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chain_reset();
    crst = 1'b1; step(1); crst = 1'b0;
  endtask

  task automatic wr(logic [7:0] d);
    we = 1'b1; wd = d; step(1); we = 1'b0;
  endtask

  initial begin
    #(150000 * 5ns);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    // R1: reset state
    expect_v("R1", 0, 1'b0); expect_v("R1", 1, 1'b0); expect_v("R1", 2, 1'b0);
    monitor();
    rst_n = 1'b1; step(1);
    en = 1'b1;

    // R3 R4 R5: half-second and full-second timing from chain reset
    chain_reset();
    step(16383); expect_v("R4", 1, 1'b0); monitor();
    step(1);     expect_v("R4", 1, 1'b1); monitor();
    step(16383); expect_v("R5", 2, 1'b0); expect_v("R4", 1, 1'b1); monitor();
    step(1);     expect_v("R5", 2, 1'b1); expect_v("R4", 1, 1'b0); monitor();
    step(1);     expect_v("R5", 2, 1'b0); monitor();

    // R7 R8: test tone with level bit 0 ignored
    crst = 1'b1; we = 1'b1; wd = 8'h40; step(1); crst = 1'b0; we = 1'b0;
    expect_v("R8", 0, 1'b1); monitor();
    step(31); expect_v("R8", 0, 1'b1); monitor();
    step(1);  expect_v("R8", 0, 1'b0); monitor();
    step(32); expect_v("R8", 0, 1'b1); monitor();

    // R7: other bits ignored; test on, level on, junk in low bits
    chain_reset(); wr(8'hFF);
    expect_v("R7", 0, 1'b1); monitor();
    step(32); expect_v("R7", 0, 1'b0); monitor();

    // R9: static level
    wr(8'h3F); expect_v("R9", 0, 1'b1); monitor();
    step(40);  expect_v("R9", 0, 1'b1); monitor();
    wr(8'h80); expect_v("R9", 0, 1'b0); monitor();
    step(40);  expect_v("R9", 0, 1'b0); monitor();

    // R6 R3: stop freezes divider, chain reset wins over stop
    wr(8'h40);
    stop = 1'b1; chain_reset();
    step(100); expect_v("R6", 0, 1'b1); monitor();
    stop = 1'b0;
    step(32);  expect_v("R6", 0, 1'b0); monitor();

    // R2: no count without enable
    chain_reset();
    en = 1'b0; step(50); expect_v("R2", 0, 1'b1); monitor();
    en = 1'b1; step(31); expect_v("R2", 0, 1'b1); monitor();
    step(1);   expect_v("R2", 0, 1'b0); monitor();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule